// File: doc/BRIEF.md
# Clocked Serial Port with Character Queues

This block moves 8-bit characters between a host and a partner device over three wires: a serial clock, a data output and a data input. Characters have no parity bit and no start or stop framing. The host writes characters into a transmit queue and reads received characters from a receive queue. The serial clock can come from an internal divider, in which case the block drives it out. It can also come from the partner, in which case the block listens on the clock input.

With the internal clock, the block emits eight clock pulses per character and keeps the line high between characters. When only the receiver is enabled, it clocks characters in while the receive queue holds fewer entries than a host-set threshold. It pauses at the threshold and continues once the host reads the queue back below it. Output data changes after each falling clock edge and input data is sampled on each rising edge. Both directions send the least significant bit first.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, ser_clk_o is 1, ser_dout is 1, rx_count is 0, rx_overrun is 0 and tx_full is 0.
- R2: With the internal clock and tx_en at 1, each queued character produces exactly 8 falling edges on ser_clk_o. The character appears on ser_dout least significant bit first, and each bit is stable at the following rising edge.
- R3: With the internal clock, ser_clk_o rests at 1 between characters and whenever no character is being moved.
- R4: Each received character is assembled from ser_din sampled at the 8 rising clock edges, the first sample being bit 0. When rx_en is 1 it is appended to the receive queue, which rx_data and rx_rd present in arrival order.
- R5: With the internal clock, rx_en at 1 and tx_en at 0, a new character is clocked only while rx_count is below rx_thresh. Clocking stops once rx_count reaches rx_thresh and resumes after a read brings rx_count below it.
- R6: Taking rx_en to 0 leaves rx_count, the queued data and rx_overrun unchanged.
- R7: While tx_en is 0, the transmit shift register is cleared and ser_dout is held at 1.
- R8: The clock source (ext_clk_sel: 0 internal, 1 external) is taken only while tx_en and rx_en are both 0. ser_clk_oe is 1 for the internal source and 0 for the external one, and a change of ext_clk_sel while either enable is 1 has no effect.
- R9: A character completed while the receive queue is full is discarded and sets rx_overrun. rx_overrun stays set until overrun_clr is pulsed, and the queued characters are kept.
- R10: With the external clock, ser_clk_i passes through a two-flop synchronizer. ser_dout advances after each synchronized falling edge and ser_din is sampled after each synchronized rising edge.
- R11: tx_full is 1 when the transmit queue holds DEPTH characters, and a write while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| ext_clk_sel | input | 1 | Clock source request: 0 internal divider, 1 external |
| half_div | input | DIV_W | Internal clock half period in system clocks, minus one |
| rx_thresh | input | CNT_W | Receive-only fill threshold (1 to DEPTH) |
| tx_wr | input | 1 | Write strobe into the transmit queue |
| tx_data | input | 8 | Character to queue for transmission |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop strobe for the receive queue |
| rx_data | output | 8 | Oldest received character |
| rx_count | output | CNT_W | Receive queue fill count |
| rx_overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears rx_overrun |
| ser_clk_i | input | 1 | Serial clock from the partner |
| ser_clk_o | output | 1 | Generated serial clock |
| ser_clk_oe | output | 1 | Drive enable for the serial clock pin |
| ser_dout | output | 1 | Serial data to the partner |
| ser_din | input | 1 | Serial data from the partner |

## Verification
The assertions assume that the host changes the clock source only with both enables low and pulses rx_rd and overrun_clr for single cycles. They also assume that the threshold is kept within 1 to DEPTH. The bench changes configuration only while both enables are 0 or in the stated lock test. In external mode it holds each serial clock phase for eight system clocks, so that the synchronizer delay never overlaps a data change on ser_din. It drives ser_din only on its own falling serial clock edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CHAR_BITS = 8;
  localparam int EDGES_PER_CHAR = 2 * CHAR_BITS;
  typedef logic [CHAR_BITS-1:0] char_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic             halt,
  input  logic             start_ok,
  input  logic [DIV_W-1:0] half_div,
  input  logic             ser_clk_i,
  output logic             ser_clk_o,
  output logic             fall_p,
  output logic             rise_p
);
  import ssp_pkg::*;
  localparam int ECW = $clog2(EDGES_PER_CHAR);

  logic [2:0]       sync_q;
  logic             ext_fall, ext_rise;
  logic             busy, sck_q, int_fall, int_rise;
  logic [DIV_W-1:0] tick_cnt;
  logic [ECW-1:0]   edge_cnt;

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 3'b111;
    else     sync_q <= {sync_q[1:0], ser_clk_i};
  end
  assign ext_fall = sync_q[2] & ~sync_q[1];
  assign ext_rise = ~sync_q[2] & sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck_q    <= 1'b1;
      int_fall <= 1'b0;
      int_rise <= 1'b0;
      tick_cnt <= '0;
      edge_cnt <= '0;
    end else begin
      int_fall <= 1'b0;
      int_rise <= 1'b0;
      if (halt || ext_mode) begin
        busy  <= 1'b0;
        sck_q <= 1'b1;
      end else if (!busy) begin
        // one idle cycle after a character lets the receive count settle
        if (start_ok && !int_rise) begin
          busy     <= 1'b1;
          tick_cnt <= '0;
          edge_cnt <= '0;
        end
      end else if (tick_cnt == half_div) begin
        tick_cnt <= '0;
        sck_q    <= ~sck_q;
        edge_cnt <= edge_cnt + ECW'(1);
        if (sck_q) int_fall <= 1'b1;
        else       int_rise <= 1'b1;
        if (edge_cnt == ECW'(EDGES_PER_CHAR - 1)) busy <= 1'b0;
      end else begin
        tick_cnt <= tick_cnt + DIV_W'(1);
      end
    end
  end

  assign ser_clk_o = sck_q;
  assign fall_p    = ext_mode ? ext_fall : int_fall;
  assign rise_p    = ext_mode ? ext_rise : int_rise;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             ext_clk_sel,
  input  logic [DIV_W-1:0] half_div,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_overrun,
  input  logic             overrun_clr,
  input  logic             ser_clk_i,
  output logic             ser_clk_o,
  output logic             ser_clk_oe,
  output logic             ser_dout,
  input  logic             ser_din
);
  import ssp_pkg::*;

  logic             src_ext, halt, start_ok, fall_p, rise_p;
  logic             tx_empty, tx_pop, rx_full, rx_empty, rx_push;
  logic [CNT_W-1:0] tx_count;
  char_t            tx_head, tx_sh, rx_sh, rx_word;
  logic [2:0]       bit_idx;
  logic             dout_q, ovr_q;

  assign halt = !tx_en && !rx_en;

  // clock source is latched only while both directions are off
  always_ff @(posedge clk) begin
    if (rst)       src_ext <= 1'b0;
    else if (halt) src_ext <= ext_clk_sel;
  end
  assign ser_clk_oe = ~src_ext;

  assign start_ok = (tx_en && !tx_empty) ||
                    (rx_en && !tx_en && (rx_count < rx_thresh));

  ssp_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .ext_mode  (src_ext),
    .halt      (halt),
    .start_ok  (start_ok),
    .half_div  (half_div),
    .ser_clk_i (ser_clk_i),
    .ser_clk_o (ser_clk_o),
    .fall_p    (fall_p),
    .rise_p    (rise_p)
  );

  ssp_fifo #(.W(CHAR_BITS), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .wr    (tx_wr),
    .wdata (tx_data),
    .rd    (tx_pop),
    .rdata (tx_head),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign tx_pop  = fall_p && (bit_idx == 3'd0) && tx_en && !tx_empty;
  assign rx_word = {ser_din, rx_sh[CHAR_BITS-1:1]};
  assign rx_push = rise_p && rx_en && (bit_idx == 3'd7);

  ssp_fifo #(.W(CHAR_BITS), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .wr    (rx_push),
    .wdata (rx_word),
    .rd    (rx_rd),
    .rdata (rx_data),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      dout_q  <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (halt)        bit_idx <= '0;
      else if (rise_p) bit_idx <= bit_idx + 3'd1;

      if (!tx_en) begin
        tx_sh  <= '0;
        dout_q <= 1'b1;
      end else if (fall_p) begin
        if (bit_idx == 3'd0) begin
          if (!tx_empty) begin
            dout_q <= tx_head[0];
            tx_sh  <= {1'b1, tx_head[CHAR_BITS-1:1]};
          end else begin
            dout_q <= 1'b1;
            tx_sh  <= '1;
          end
        end else begin
          dout_q <= tx_sh[0];
          tx_sh  <= {1'b1, tx_sh[CHAR_BITS-1:1]};
        end
      end

      if (rise_p && !halt) rx_sh <= rx_word;

      if (rx_push && rx_full) ovr_q <= 1'b1;
      else if (overrun_clr)   ovr_q <= 1'b0;
    end
  end

  assign ser_dout   = dout_q;
  assign rx_overrun = ovr_q;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             rx_en,
  input logic             rx_rd,
  input logic             overrun_clr,
  input logic             ser_clk_o,
  input logic             ser_clk_oe,
  input logic             ser_dout,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_overrun
);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (ser_clk_o && ser_dout && rx_count == '0 && !rx_overrun));

  a_r3_clock_rests_high: assert property (@(posedge clk) disable iff (rst)
    $past(!tx_en && !rx_en) |-> ser_clk_o);

  a_r7_dout_idle_high: assert property (@(posedge clk) disable iff (rst)
    $past(!tx_en) |-> ser_dout);

  a_r8_source_locked: assert property (@(posedge clk) disable iff (rst)
    $past(tx_en || rx_en) |-> $stable(ser_clk_oe));

  a_r6_count_kept: assert property (@(posedge clk) disable iff (rst)
    $past(!rx_en && !rx_rd) |-> $stable(rx_count));

  a_r6_overrun_kept: assert property (@(posedge clk) disable iff (rst)
    $past(!rx_en && !overrun_clr) |-> !$fell(rx_overrun));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !overrun_clr) |=> rx_overrun);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH));
endmodule

bind sync_serial_port ssp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .rx_rd       (rx_rd),
  .overrun_clr (overrun_clr),
  .ser_clk_o   (ser_clk_o),
  .ser_clk_oe  (ser_clk_oe),
  .ser_dout    (ser_dout),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun)
);

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
  localparam int DIV_W = 8;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, rx_en = 0, ext_clk_sel = 0, tx_wr = 0, rx_rd = 0, overrun_clr = 0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic [CW-1:0] rx_thresh = CW'(DEPTH);
  logic [7:0] tx_data = 8'h00;
  logic tx_full, rx_overrun, ser_clk_o, ser_clk_oe, ser_dout, ser_din;
  logic [7:0] rx_data;
  logic [CW-1:0] rx_count;
  logic ser_clk_i = 1'b1, din_drv = 1'b1, loopback = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign ser_din = loopback ? ser_dout : din_drv;

  sync_serial_port #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .ext_clk_sel(ext_clk_sel),
    .half_div(half_div), .rx_thresh(rx_thresh), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_count(rx_count),
    .rx_overrun(rx_overrun), .overrun_clr(overrun_clr), .ser_clk_i(ser_clk_i),
    .ser_clk_o(ser_clk_o), .ser_clk_oe(ser_clk_oe), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  // line monitor for the internally generated clock
  int falls = 0, nbits = 0, ncap = 0;
  logic [7:0] shf = 0;
  logic [7:0] cap [8];
  logic prev_sck = 1'b1;
  always @(negedge clk) begin
    if (ser_clk_oe && prev_sck && !ser_clk_o) falls++;
    if (ser_clk_oe && !prev_sck && ser_clk_o) begin
      shf = {ser_dout, shf[7:1]};
      nbits++;
      if (nbits % 8 == 0 && ncap < 8) begin
        cap[ncap] = shf;
        ncap++;
      end
    end
    prev_sck = ser_clk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(negedge clk);
    falls = 0; nbits = 0; ncap = 0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk); d = rx_data; rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic wait_count(input int n);
    for (int i = 0; i < 5000 && rx_count != CW'(n); i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 clk", ser_clk_o, 1);
    chk("R1 dout", ser_dout, 1);
    chk("R1 count", rx_count, 0);
    chk("R1 overrun", rx_overrun, 0);
    chk("R1 full", tx_full, 0);
  endtask

  task automatic t_tx_loop();
    logic [7:0] d;
    loopback = 1;
    push_tx(8'hA5);
    push_tx(8'h3C);
    mon_clear();
    tx_en = 1; rx_en = 1;
    wait_count(2);
    idle(30);
    chk("R2 falls", falls, 16);
    chk("R2 byte0", cap[0], 8'hA5);
    chk("R2 byte1", cap[1], 8'h3C);
    chk("R3 idle high", ser_clk_o, 1);
    pop_rx(d); chk("R4 rx0", d, 8'hA5);
    pop_rx(d); chk("R4 rx1", d, 8'h3C);
    tx_en = 0; rx_en = 0; loopback = 0;
    idle(4);
  endtask

  task automatic t_rx_only();
    logic [7:0] d;
    din_drv = 1; rx_thresh = 2;
    mon_clear();
    rx_en = 1;
    wait_count(2);
    idle(100);
    chk("R5 paused falls", falls, 16);
    chk("R5 count", rx_count, 2);
    chk("R7 dout", ser_dout, 1);
    pop_rx(d); chk("R4 rx ones", d, 8'hFF);
    wait_count(2);
    idle(100);
    chk("R5 resumed falls", falls, 24);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rx_en = 0;
    idle(50);
    chk("R6 count kept", rx_count, 2);
    chk("R6 overrun kept", rx_overrun, 0);
    chk("R6 data kept", rx_data, 8'hFF);
    chk("R3 halted high", ser_clk_o, 1);
    pop_rx(d); pop_rx(d);
    chk("R6 drained", rx_count, 0);
  endtask

  task automatic t_lock();
    tx_en = 1; idle(2);
    ext_clk_sel = 1; idle(5);
    chk("R8 locked", ser_clk_oe, 1);
    tx_en = 0; idle(3);
    chk("R8 taken", ser_clk_oe, 0);
  endtask

  task automatic ext_char(input logic [7:0] b, output logic [7:0] seen);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ser_clk_i = 0; din_drv = b[i];
      idle(8);
      @(negedge clk); ser_clk_i = 1; seen = {ser_dout, seen[7:1]};
      idle(8);
    end
  endtask

  task automatic t_ext();
    logic [7:0] seen, d;
    seen = 0;
    push_tx(8'h96);
    tx_en = 1; rx_en = 1;
    ext_char(8'h5A, seen);
    idle(10);
    chk("R10 dout byte", seen, 8'h96);
    chk("R10 rx count", rx_count, 1);
    chk("R10 rx byte", rx_data, 8'h5A);
    chk("R10 oe off", ser_clk_oe, 0);
    tx_en = 0;
    ext_char(8'h11, seen);
    ext_char(8'h22, seen);
    ext_char(8'h33, seen);
    ext_char(8'h44, seen);
    idle(10);
    chk("R9 overrun set", rx_overrun, 1);
    chk("R9 count full", rx_count, DEPTH);
    @(negedge clk); overrun_clr = 1;
    @(negedge clk); overrun_clr = 0;
    chk("R9 overrun cleared", rx_overrun, 0);
    pop_rx(d); chk("R9 first kept", d, 8'h5A);
    pop_rx(d); pop_rx(d);
    pop_rx(d); chk("R9 last kept", d, 8'h33);
    rx_en = 0;
    idle(4);
    ext_clk_sel = 0;
    idle(4);
  endtask

  task automatic t_full();
    logic [7:0] d;
    for (int i = 1; i <= 5; i++) push_tx(8'(i));
    chk("R11 full", tx_full, 1);
    loopback = 1;
    tx_en = 1; rx_en = 1;
    wait_count(4);
    idle(200);
    chk("R11 dropped", rx_count, 4);
    for (int i = 1; i <= 4; i++) begin
      pop_rx(d); chk("R11 order", d, i);
    end
    tx_en = 0; rx_en = 0; loopback = 0;
  endtask

  initial begin
    idle(4);
    rst = 0;
    t_reset();
    t_tx_loop();
    t_rx_only();
    t_hold();
    t_lock();
    t_ext();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule